// File: doc/BRIEF.md
# Noise-shaped repeat/take sample-rate converter

This block raises the sample rate of an audio stream without any interpolation arithmetic. An external output-rate tick paces the block, and every tick produces exactly one output sample. On each tick a third-order, single-bit sigma-delta modulator makes a binary choice. A positive decision repeats the sample that was last emitted. A negative decision emits the next buffered input sample unchanged. The modulator is driven by a constant control word and not by the audio. Because of this, the timing error that repetition introduces is noise-shaped toward high frequencies.

The control word is a signed Q1.15 value. It is set to 1 − 2·Fin/Fout, so the long-run fraction of take decisions equals Fin/Fout, and it may be changed at run time. Input samples enter through a one-entry holding slot with a valid/ready handshake. `in_ready` is high exactly when the slot is empty. A sample is accepted on a clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low the source must hold its sample. A source that asserts `in_valid` against a full slot is flagged as an overflow, and that sample is not captured. The output side has no back-pressure: `out_valid` pulses once per tick and cannot be stalled.

Top module: `repeat_take_src`

## Requirements
- R1: After reset `out_data` is 0, `out_valid`, `underrun` and `overflow` are 0, `in_ready` is 1, and all three integrators hold 0, so the first tick always repeats (the output stays 0).
- R2: `out_valid` is high in the cycle after each cycle where `tick` is high, and low after every cycle where `tick` is low.
- R3: The modulator uses these definitions. x is the control word sign-extended to 24 bits. v is +32768 when integrator s3 ≥ 0 and −32768 otherwise. On each tick, s1 ← sat(s1 + x − v), s2 ← sat(s2 + (s1 >>> 1) − v) and s3 ← sat(s3 + (s2 >>> 2) − v), all using pre-tick values, where sat clamps to [−2^23, 2^23−1]. A positive v means repeat and a negative v means take.
- R4: On a take tick with a sample in the slot, `out_data` becomes that sample one cycle later and the slot is emptied.
- R5: On a repeat tick, and in every cycle without a tick, `out_data` is unchanged and a buffered sample stays in the slot.
- R6: Samples leave in the order they were accepted, none is skipped, and each appears at least once.
- R7: A take tick that finds the slot empty leaves `out_data` unchanged and sets `underrun`, which stays high until reset.
- R8: `in_valid` high while the slot is full sets `overflow`, which stays high until reset; the offered sample is not captured and the buffered one is kept.
- R9: `in_ready` equals "slot empty"; an accepted sample makes `in_ready` low from the next cycle until a take tick consumes it.
- R10: A new control word takes effect at the first tick after it is applied, without resetting the integrators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Output-rate strobe, one output sample per high cycle |
| rate_ctrl | input | 16 | Signed Q1.15 control level driving the modulator |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Holding slot empty, sample will be accepted |
| in_data | input | 24 | Input audio sample |
| out_valid | output | 1 | Output sample strobe, one cycle after each tick |
| out_data | output | 24 | Output audio sample |
| underrun | output | 1 | Sticky: a take found no buffered sample |
| overflow | output | 1 | Sticky: a sample was offered while the slot was full |

## Verification
Every result of a tick is registered once. The decision, `out_data`, `out_valid` and `underrun` therefore all change on the edge that samples the tick, and are due in the following cycle. Slot occupancy (`in_ready`) and `overflow` likewise move on the edge that sees the handshake or the offending `in_valid`. The bench drives inputs on the falling edge. It predicts the effect of the next rising edge from its own model of the R3 recurrences and of the slot. It compares at the following falling edge, exactly one register stage after the stimulus.

// File: rtl/src_pkg.sv
package src_pkg;
  localparam int CTRL_W = 16;
  localparam int GUARD_W = 8;
  localparam int ACC_W = CTRL_W + GUARD_W;
  localparam int SAMPLE_W = 24;

  typedef enum logic {
    ACT_TAKE   = 1'b0,
    ACT_REPEAT = 1'b1
  } src_act_e;
endpackage

// File: rtl/src_integ.sv
module src_integ #(
  parameter int AW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [AW-1:0] din,
  input  logic signed [AW-1:0] fb,
  output logic signed [AW-1:0] acc
);
  localparam logic signed [AW+1:0] HI = {3'b000, {(AW-1){1'b1}}};
  localparam logic signed [AW+1:0] LO = {3'b111, {(AW-1){1'b0}}};

  logic signed [AW+1:0] sum;
  logic signed [AW-1:0] clamped;

  always_comb begin
    sum = {{2{acc[AW-1]}}, acc} + {{2{din[AW-1]}}, din} - {{2{fb[AW-1]}}, fb};
    if (sum > HI)      clamped = HI[AW-1:0];
    else if (sum < LO) clamped = LO[AW-1:0];
    else               clamped = sum[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= clamped;
  end
endmodule

// File: rtl/src_dsm.sv
module src_dsm
  import src_pkg::*;
#(
  parameter int CW    = 16,
  parameter int GUARD = 8,
  parameter int ORDER = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic signed [CW-1:0] level,
  output src_act_e             action
);
  localparam int AW = CW + GUARD;
  localparam logic signed [AW-1:0] FS_POS = {{GUARD{1'b0}}, 1'b1, {(CW-1){1'b0}}};
  localparam logic signed [AW-1:0] FS_NEG = {{(GUARD+1){1'b1}}, {(CW-1){1'b0}}};

  logic signed [AW-1:0] stage_q [ORDER];
  logic signed [AW-1:0] stage_in [ORDER];
  logic signed [AW-1:0] feedback;
  logic                 pos_decision;

  assign pos_decision = !stage_q[ORDER-1][AW-1];
  assign feedback     = pos_decision ? FS_POS : FS_NEG;
  assign action       = pos_decision ? ACT_REPEAT : ACT_TAKE;

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign stage_in[k] = {{GUARD{level[CW-1]}}, level};
    end else begin : g_chain
      assign stage_in[k] = stage_q[k-1] >>> k;
    end
    src_integ #(.AW(AW)) u_integ (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (tick),
      .din  (stage_in[k]),
      .fb   (feedback),
      .acc  (stage_q[k])
    );
  end
endmodule

// File: rtl/src_slot.sv
module src_slot #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          take_req,
  output logic [DW-1:0] slot_data,
  output logic          consume,
  output logic          starve,
  output logic          clash
);
  logic full_q;

  assign in_ready = !full_q;
  assign consume  = take_req && full_q;
  assign starve   = take_req && !full_q;
  assign clash    = in_valid && full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q    <= 1'b0;
      slot_data <= '0;
    end else begin
      if (consume) full_q <= 1'b0;
      if (in_valid && !full_q) begin
        full_q    <= 1'b1;
        slot_data <= in_data;
      end
    end
  end
endmodule

// File: rtl/src_outstage.sv
module src_outstage #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          consume,
  input  logic [DW-1:0] slot_data,
  input  logic          starve,
  input  logic          clash,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          underrun,
  output logic          overflow
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      underrun  <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      out_valid <= tick;
      if (consume) out_data <= slot_data;
      if (starve)  underrun <= 1'b1;
      if (clash)   overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/repeat_take_src.sv
module repeat_take_src
  import src_pkg::*;
#(
  parameter int DW    = SAMPLE_W,
  parameter int CW    = CTRL_W,
  parameter int GUARD = GUARD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic signed [CW-1:0] rate_ctrl,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DW-1:0]        in_data,
  output logic                 out_valid,
  output logic [DW-1:0]        out_data,
  output logic                 underrun,
  output logic                 overflow
);
  src_act_e      action;
  logic          take_req;
  logic [DW-1:0] slot_data;
  logic          consume;
  logic          starve;
  logic          clash;

  assign take_req = tick && (action == ACT_TAKE);

  src_dsm #(.CW(CW), .GUARD(GUARD), .ORDER(3)) u_dsm (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .level (rate_ctrl),
    .action(action)
  );

  src_slot #(.DW(DW)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .take_req (take_req),
    .slot_data(slot_data),
    .consume  (consume),
    .starve   (starve),
    .clash    (clash)
  );

  src_outstage #(.DW(DW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .consume  (consume),
    .slot_data(slot_data),
    .starve   (starve),
    .clash    (clash),
    .out_valid(out_valid),
    .out_data (out_data),
    .underrun (underrun),
    .overflow (overflow)
  );
endmodule

// File: rtl/src_checks.sv
module src_checks #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          underrun,
  input logic          overflow
);
  AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n) tick |=> out_valid); // R2
  AST_QUIET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> !out_valid); // R2
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(out_data)); // R5
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) underrun |=> underrun); // R7
  AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(underrun) |-> $past(tick && in_ready)); // R7
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow); // R8
  AST_OVERFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(overflow) |-> $past(in_valid && !in_ready)); // R8
  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> !in_ready); // R9
endmodule

bind repeat_take_src src_checks #(.DW(DW)) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_data (out_data),
  .underrun (underrun),
  .overflow (overflow)
);

// File: tb/repeat_take_src_bench.sv
module repeat_take_src_bench;
  localparam int DW = 24;
  localparam longint SAT_HI = 64'sd8388607;
  localparam longint SAT_LO = -64'sd8388608;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               tick = 1'b0;
  logic signed [15:0] rate_ctrl = '0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [DW-1:0]      in_data = '0;
  logic               out_valid;
  logic [DW-1:0]      out_data;
  logic               underrun;
  logic               overflow;

  int checks = 0;
  int failures = 0;

  longint m_s [3];
  bit            m_full;
  logic [DW-1:0] m_slot;
  logic [DW-1:0] exp_out;
  bit            exp_under;
  bit            exp_ovf;
  logic [DW-1:0] next_val;
  bit            feed_on;
  bit            force_valid;

  always #5 clk = ~clk;

  repeat_take_src u_repeat_take_src (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rate_ctrl(rate_ctrl),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .underrun(underrun), .overflow(overflow)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > SAT_HI) return SAT_HI;
    if (v < SAT_LO) return SAT_LO;
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; in_valid = 1'b0; feed_on = 0; force_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    foreach (m_s[i]) m_s[i] = 0;
    m_full = 0; m_slot = '0; exp_out = '0; exp_under = 0; exp_ovf = 0;
  endtask

  // One clock cycle: drive at the falling edge, predict the next rising edge, compare at the next falling edge.
  task automatic step(input bit t, input string tag);
    bit old_full, rep, hs;
    longint v, x, n0, n1, n2;
    tick = t;
    in_valid = feed_on && (force_valid || in_ready);
    in_data = next_val;
    old_full = m_full;
    hs = in_valid && !old_full;
    if (in_valid && old_full) exp_ovf = 1;
    if (t) begin
      rep = (m_s[2] >= 0);
      v = rep ? 64'sd32768 : -64'sd32768;
      x = longint'(rate_ctrl);
      n0 = sat(m_s[0] + x - v);
      n1 = sat(m_s[1] + (m_s[0] >>> 1) - v);
      n2 = sat(m_s[2] + (m_s[1] >>> 2) - v);
      m_s[0] = n0; m_s[1] = n1; m_s[2] = n2;
      if (!rep) begin
        if (old_full) begin exp_out = m_slot; m_full = 0; end
        else exp_under = 1;
      end
    end
    if (hs) begin
      m_full = 1; m_slot = in_data; next_val = next_val + 1;
    end
    @(negedge clk);
    check(out_valid == t, {tag, " R2 out_valid"}, out_valid, t);
    check(out_data == exp_out, {tag, " R3/R4/R5/R6 out_data"}, out_data, exp_out);
    check(underrun == exp_under, {tag, " R7 underrun"}, underrun, exp_under);
    check(overflow == exp_ovf, {tag, " R8 overflow"}, overflow, exp_ovf);
    check(in_ready == !m_full, {tag, " R9 in_ready"}, in_ready, !m_full);
  endtask

  task automatic run_ticks(input int n, input int spacing, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1'b1, tag);
      for (int j = 1; j < spacing; j++) step(1'b0, tag);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check(out_data == 0, "R1 out_data after reset", out_data, 0);
    check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    check(underrun == 0 && overflow == 0, "R1 flags after reset", {underrun, overflow}, 0);
    check(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
    next_val = 24'h000101;
    feed_on = 1;
    step(1'b0, "R1 fill");
    step(1'b1, "R1 first tick");
    check(out_data == 0, "R1 first tick repeats", out_data, 0);
  endtask

  task automatic t_stream(input logic signed [15:0] lvl, input int n, input string tag);
    rate_ctrl = lvl;
    feed_on = 1;
    run_ticks(n, 4, tag);
  endtask

  task automatic t_ctrl_change();
    t_stream(16'sd22921, 80, "R10 before change");
    t_stream(16'sd16384, 120, "R10 after change");
    t_stream(-16'sd16384, 120, "R10 low level");
  endtask

  task automatic t_underrun();
    do_reset();
    next_val = 24'h000200;
    rate_ctrl = -16'sd16384;
    feed_on = 0;
    run_ticks(20, 1, "R7 starve");
    check(underrun == 1, "R7 underrun raised", underrun, 1);
    check(out_data == 0, "R7 output held", out_data, 0);
    feed_on = 1;
    run_ticks(30, 4, "R7 recover");
    check(underrun == 1, "R7 underrun sticky", underrun, 1);
  endtask

  task automatic t_overflow();
    do_reset();
    next_val = 24'h000300;
    rate_ctrl = 16'sd0;
    feed_on = 1;
    force_valid = 1;
    for (int i = 0; i < 6; i++) step(1'b0, "R8 push");
    check(overflow == 1, "R8 overflow raised", overflow, 1);
    check(in_ready == 0, "R9 slot stays full", in_ready, 0);
    force_valid = 0;
    run_ticks(40, 4, "R8 drain");
    check(overflow == 1, "R8 overflow sticky", overflow, 1);
  endtask

  task automatic t_extremes();
    do_reset();
    next_val = 24'h000400;
    t_stream(-16'sd32768, 60, "R3 full take level");
    t_stream(16'sd32767, 60, "R3 full repeat level");
    t_stream(16'sd24576, 200, "R3 upper level");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_stream(16'sd22921, 300, "R6 stream");
    t_ctrl_change();
    t_underrun();
    t_overflow();
    t_extremes();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule